// File: doc/BRIEF.md
# Tiled Monochrome Pixel Renderer

This block turns a 640x480 raster position into a colour for a display whose picture is a grid of 40 columns by 30 rows of square tiles, each tile 16x16 pixels and one bit deep. Each cycle it takes the horizontal and vertical pixel counters and their active flags, sends the tile row index to an external framebuffer, receives that row back one cycle later as a 40-bit word, and picks the bit of the current tile column.

The polarity is inverted: a set tile is painted black and a clear tile white, so the picture is dark marks on a light field. Outside the visible area every colour output is black. Colour leaves as 3 red, 3 green and 2 blue bits from registers. The counters, the sync pulses and the framebuffer storage belong to neighbouring blocks.

Internally a three-state shade register holds the class of the pixel now on the outputs. SHADE_BLANK (blanking) goes to SHADE_INK when the aligned pixel is active and its bit is set, to SHADE_PAPER when it is active and clear, and back to SHADE_BLANK when either flag is low. The same decisions lead out of every state, so each state can go to any of the three. Reset forces SHADE_BLANK.

Top module: `tile_renderer`

## Requirements
- R1: `row_idx` equals `vcount` divided by 16. It follows `vcount` in the same cycle, with no register.
- R2: The tile column is `hcount` divided by 16. Bit c of `row_word` (bit 0 = leftmost column) belongs to column c.
- R3: With both active flags high and the selected tile bit set, `red`, `green` and `blue` are all zero.
- R4: With both active flags high and the selected tile bit clear, the outputs are `red`=3'b111, `green`=3'b111 and `blue`=2'b11.
- R5: When `h_act` or `v_act` is low, all colour outputs are zero, whatever the counters and `row_word` hold.
- R6: The framebuffer returns `row_word` one clock edge after `row_idx`. The colour for a set of counter inputs appears on the outputs after the second rising edge that follows those inputs, and an isolated active pixel affects exactly one output cycle.
- R7: While `rst` is high, the colour outputs are zero after the next rising edge (state SHADE_BLANK).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| hcount | input | 10 | Horizontal pixel counter |
| vcount | input | 10 | Vertical pixel counter |
| h_act | input | 1 | High during visible pixels of a line |
| v_act | input | 1 | High during visible lines of a frame |
| row_word | input | 40 | Tile row read back from the framebuffer, one edge after `row_idx` |
| row_idx | output | 5 | Tile row address sent to the framebuffer |
| red | output | 3 | Red intensity |
| green | output | 3 | Green intensity |
| blue | output | 2 | Blue intensity |

## Verification
The row address is combinational, so the bench reads `row_idx` a moment after it drives `vcount`, within the same cycle. Colour results are due two rising edges after their counters. The bench drives inputs on falling edges and keeps a two-slot queue of expected colours, comparing each entry exactly two falling edges after it was queued. Its framebuffer model returns the row one edge after the address. The latency scenario sends a lone active pixel and looks at the neighbouring output cycles, which shows the result is neither early nor late.

// File: rtl/tile_pkg.sv
package tile_pkg;
    typedef enum logic [1:0] {
        SHADE_BLANK = 2'd0,
        SHADE_INK   = 2'd1,
        SHADE_PAPER = 2'd2
    } shade_e;
endpackage

// File: rtl/tile_addr.sv
module tile_addr #(
    parameter int CNT_W      = 10,
    parameter int TILE_SHIFT = 4,
    parameter int COL_W      = 6,
    parameter int ROW_W      = 5
) (
    input  logic [CNT_W-1:0] hcount,
    input  logic [CNT_W-1:0] vcount,
    output logic [COL_W-1:0] col,
    output logic [ROW_W-1:0] row
);
    // tile coordinate = pixel coordinate with the in-tile bits dropped
    assign col = hcount[TILE_SHIFT +: COL_W];
    assign row = vcount[TILE_SHIFT +: ROW_W];
endmodule

// File: rtl/tile_align.sv
module tile_align #(
    parameter int COL_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             act_in,
    input  logic [COL_W-1:0] col_in,
    output logic             act_q,
    output logic [COL_W-1:0] col_q
);
    // one-stage delay matching the framebuffer's registered read
    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= 1'b0;
            col_q <= '0;
        end else begin
            act_q <= act_in;
            col_q <= col_in;
        end
    end
endmodule

// File: rtl/tile_shade.sv
module tile_shade #(
    parameter int COLS  = 40,
    parameter int COL_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             act_q,
    input  logic [COL_W-1:0] col_q,
    input  logic [COLS-1:0]  row_word,
    output logic [2:0]       red,
    output logic [2:0]       green,
    output logic [1:0]       blue
);
    import tile_pkg::*;

    shade_e          shade_q;
    shade_e          shade_d;
    logic [COLS-1:0] shifted;
    logic            tile_bit;

    always_comb begin
        shifted  = row_word >> col_q;
        tile_bit = (int'(col_q) < COLS) ? shifted[0] : 1'b0;
    end

    always_comb begin
        if (!act_q)
            shade_d = SHADE_BLANK;
        else if (tile_bit)
            shade_d = SHADE_INK;
        else
            shade_d = SHADE_PAPER;
    end

    always_ff @(posedge clk) begin
        if (rst)
            shade_q <= SHADE_BLANK;
        else
            shade_q <= shade_d;
    end

    always_comb begin
        unique case (shade_q)
            SHADE_PAPER: begin
                red   = 3'b111;
                green = 3'b111;
                blue  = 2'b11;
            end
            SHADE_INK, SHADE_BLANK: begin
                red   = 3'b000;
                green = 3'b000;
                blue  = 2'b00;
            end
            default: begin
                red   = 3'b000;
                green = 3'b000;
                blue  = 2'b00;
            end
        endcase
    end
endmodule

// File: rtl/tile_renderer.sv
module tile_renderer #(
    parameter int H_PIX      = 640,
    parameter int V_PIX      = 480,
    parameter int TILE_SHIFT = 4,
    parameter int CNT_W      = 10,
    localparam int COLS      = H_PIX >> TILE_SHIFT,
    localparam int ROWS      = V_PIX >> TILE_SHIFT,
    localparam int COL_W     = $clog2(COLS),
    localparam int ROW_W     = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] hcount,
    input  logic [CNT_W-1:0] vcount,
    input  logic             h_act,
    input  logic             v_act,
    input  logic [COLS-1:0]  row_word,
    output logic [ROW_W-1:0] row_idx,
    output logic [2:0]       red,
    output logic [2:0]       green,
    output logic [1:0]       blue
);
    logic [COL_W-1:0] col_now;
    logic [COL_W-1:0] col_q;
    logic             act_q;

    tile_addr #(
        .CNT_W(CNT_W), .TILE_SHIFT(TILE_SHIFT), .COL_W(COL_W), .ROW_W(ROW_W)
    ) u_addr (
        .hcount(hcount), .vcount(vcount), .col(col_now), .row(row_idx)
    );

    tile_align #(.COL_W(COL_W)) u_align (
        .clk(clk), .rst(rst), .act_in(h_act & v_act), .col_in(col_now),
        .act_q(act_q), .col_q(col_q)
    );

    tile_shade #(.COLS(COLS), .COL_W(COL_W)) u_shade (
        .clk(clk), .rst(rst), .act_q(act_q), .col_q(col_q),
        .row_word(row_word), .red(red), .green(green), .blue(blue)
    );
endmodule

// File: rtl/tile_renderer_chk.sv
module tile_renderer_chk #(
    parameter int H_PIX      = 640,
    parameter int V_PIX      = 480,
    parameter int TILE_SHIFT = 4,
    parameter int CNT_W      = 10,
    localparam int COLS      = H_PIX >> TILE_SHIFT,
    localparam int ROWS      = V_PIX >> TILE_SHIFT,
    localparam int COL_W     = $clog2(COLS),
    localparam int ROW_W     = $clog2(ROWS)
) (
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] hcount,
    input logic [CNT_W-1:0] vcount,
    input logic             h_act,
    input logic             v_act,
    input logic [COLS-1:0]  row_word,
    input logic [ROW_W-1:0] row_idx,
    input logic [2:0]       red,
    input logic [2:0]       green,
    input logic [1:0]       blue
);
    logic             act_d1, act_d2;
    logic [CNT_W-1:0] h_d1;
    logic [COLS-1:0]  sel_word;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_d1 <= 1'b0;
            act_d2 <= 1'b0;
            h_d1   <= '0;
        end else begin
            act_d1 <= h_act & v_act;
            act_d2 <= act_d1;
            h_d1   <= hcount;
        end
    end

    assign sel_word = row_word >> (h_d1 >> TILE_SHIFT);

    // R1: visible lines address a row inside the map
    a_r1_row_in_map: assert property (@(posedge clk) disable iff (rst)
        (v_act && vcount < V_PIX) |-> (int'(row_idx) < ROWS));

    // R3: active set tile gives black on the following cycle
    a_r3_ink_black: assert property (@(posedge clk) disable iff (rst)
        (act_d1 && sel_word[0]) |=> ({red, green, blue} == 8'h00));

    // R4: active clear tile gives full white on the following cycle
    a_r4_paper_white: assert property (@(posedge clk) disable iff (rst)
        (act_d1 && !sel_word[0] && (h_d1 < H_PIX)) |=> ({red, green, blue} == 8'hFF));

    // R5: blanking two edges back keeps all colours at zero
    a_r5_blank_black: assert property (@(posedge clk) disable iff (rst)
        !act_d2 |-> ({red, green, blue} == 8'h00));

    // R4: the outputs are only ever full black or full white
    a_r4_two_levels: assert property (@(posedge clk) disable iff (rst)
        ({red, green, blue} == 8'h00) || ({red, green, blue} == 8'hFF));

    // R7: reset clears the colours at the next edge
    a_r7_reset_black: assert property (@(posedge clk)
        rst |=> ({red, green, blue} == 8'h00));
endmodule

bind tile_renderer tile_renderer_chk #(
    .H_PIX(H_PIX), .V_PIX(V_PIX), .TILE_SHIFT(TILE_SHIFT), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/test_tile_renderer.sv
module test_tile_renderer;
    localparam int COLS = 40;
    localparam int ROWS = 30;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [9:0]  hcount = '0;
    logic [9:0]  vcount = '0;
    logic        h_act = 1'b0;
    logic        v_act = 1'b0;
    logic [39:0] row_word;
    logic [4:0]  row_idx;
    logic [2:0]  red, green;
    logic [1:0]  blue;

    int n_checks = 0;
    int n_fail   = 0;

    logic [39:0] fb [ROWS];

    logic       q_v0 = 1'b0, q_v1 = 1'b0;
    logic [7:0] q_e0 = '0,   q_e1 = '0;
    string      q_t0 = "",   q_t1 = "";

    always #5 clk = ~clk;

    tile_renderer i_tile_renderer (
        .clk(clk), .rst(rst), .hcount(hcount), .vcount(vcount),
        .h_act(h_act), .v_act(v_act), .row_word(row_word),
        .row_idx(row_idx), .red(red), .green(green), .blue(blue)
    );

    // framebuffer model: registered read, one edge after the address
    always_ff @(posedge clk)
        row_word <= (int'(row_idx) < ROWS) ? fb[row_idx] : '0;

    function automatic logic tile_set(int r, int c);
        return ((r * 3 + c * 5) % 7) < 3;
    endfunction

    function automatic logic [7:0] expect_rgb(int h, int v, logic ha, logic va);
        if (!(ha && va)) return 8'h00;
        return tile_set(v / 16, h / 16) ? 8'h00 : 8'hFF;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // one pixel per call; compares the result queued two falling edges ago
    task automatic apply(int h, int v, logic ha, logic va, string tag, logic chk);
        @(negedge clk);
        if (q_v1) check(tag == "" ? q_t1 : q_t1, {24'd0, red, green, blue}, {24'd0, q_e1});
        q_v1 = q_v0; q_e1 = q_e0; q_t1 = q_t0;
        hcount = 10'(h); vcount = 10'(v); h_act = ha; v_act = va;
        q_v0 = chk; q_e0 = expect_rgb(h, v, ha, va); q_t0 = tag;
    endtask

    task automatic flush();
        apply(0, 0, 1'b0, 1'b0, "R5", 1'b0);
        apply(0, 0, 1'b0, 1'b0, "R5", 1'b0);
        apply(0, 0, 1'b0, 1'b0, "R5", 1'b0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R7", {24'd0, red, green, blue}, 32'd0);
        hcount = 10'd20; vcount = 10'd5; h_act = 1'b1; v_act = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R7", {24'd0, red, green, blue}, 32'd0);
        rst = 1'b0;
        @(negedge clk); @(negedge clk);
        check("R4", {24'd0, red, green, blue}, 32'hFF);
        rst = 1'b1;
        @(negedge clk);
        check("R7", {24'd0, red, green, blue}, 32'd0);
        h_act = 1'b0; v_act = 1'b0;
        rst = 1'b0;
        q_v0 = 1'b0; q_v1 = 1'b0;
    endtask

    task automatic t_row_addr();
        int vs [6] = '{0, 15, 16, 31, 464, 479};
        foreach (vs[i]) begin
            @(negedge clk);
            vcount = 10'(vs[i]); v_act = 1'b1;
            #1;
            check("R1", {27'd0, row_idx}, 32'(vs[i] / 16));
        end
        v_act = 1'b0;
        q_v0 = 1'b0; q_v1 = 1'b0;
    endtask

    task automatic t_scan_line(int v);
        for (int h = 0; h < 640; h += 8)
            apply(h, v, 1'b1, 1'b1,
                  tile_set(v / 16, h / 16) ? "R3" : "R4", 1'b1);
        flush();
    endtask

    task automatic t_col_edges();
        int hs [8] = '{0, 15, 16, 31, 32, 623, 624, 639};
        for (int v = 0; v < 480; v += 37)
            foreach (hs[i]) apply(hs[i], v, 1'b1, 1'b1, "R2", 1'b1);
        flush();
    endtask

    task automatic t_blanking();
        // tile (0,1) is clear, so an active pixel there would be white
        apply(20, 5, 1'b0, 1'b1, "R5", 1'b1);
        apply(20, 5, 1'b1, 1'b0, "R5", 1'b1);
        apply(20, 5, 1'b0, 1'b0, "R5", 1'b1);
        apply(20, 5, 1'b1, 1'b1, "R4", 1'b1);
        apply(700, 500, 1'b0, 1'b0, "R5", 1'b1);
        flush();
    endtask

    task automatic t_latency();
        @(negedge clk);
        hcount = 10'd20; vcount = 10'd5; h_act = 1'b1; v_act = 1'b1;
        @(negedge clk);
        h_act = 1'b0; v_act = 1'b0;
        check("R6", {24'd0, red, green, blue}, 32'd0);
        @(negedge clk);
        check("R6", {24'd0, red, green, blue}, 32'hFF);
        @(negedge clk);
        check("R6", {24'd0, red, green, blue}, 32'd0);
    endtask

    initial begin
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
                fb[r][c] = tile_set(r, c);
    end

    initial begin
        #2_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_row_addr();
        t_latency();
        flush();
        t_scan_line(0);
        t_scan_line(37);
        t_scan_line(479);
        t_col_edges();
        t_blanking();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule